// File: doc/BRIEF.md
# Fan Tachometer Period Measurement Unit

This block measures the speed of up to sixteen fans. It measures one tach input at a time. Software enables the channels it uses and programs two measurement profiles. Each profile sets the edge polarity, a tach clock prescale and a timeout window. A per-channel map bit says which profile a channel uses. A single-shot trigger write selects a channel. The unit then waits for a qualifying edge on that input and counts prescaled clock ticks until the next qualifying edge. It posts the count together with a done flag in one shared result word.

Every tach input passes through a synchronizer before its edges are detected. If the fan is stopped or missing, the window expires and the unit posts done with a count of zero. A fan that is turning but very slow gives a count that saturates at the top of the counter instead of wrapping. Turning the count into a fan speed is left to software.

Top module: `fan_tach_unit`

## Requirements
- R1: After reset the result word reads zero. Done (bit 31) is clear and the count (bits 19:0) is zero.
- R2: A trigger write starts a measurement when the trigger register held zero and the written value is non-zero. The channel must be enabled and its profile's enable bit set. The done bit reads 0 in the cycle after the accepted write.
- R3: A trigger is ignored if its channel is disabled, or if the profile it maps to has bit 0 clear. The result word stays unchanged. Channel c is enabled by control register (address 0) bit 16+c.
- R4: A trigger write made while the trigger register already holds a non-zero value starts nothing and leaves the result word unchanged.
- R5: Profile word bits 5:4 select the edge polarity: 00 counts between falling edges and 01 counts between rising edges. Profile 0 is at address 1, profile 1 is at address 2, and the trigger register is at address 4.
- R6: Edge mode 10 qualifies both edges, so the count spans half a fan pulse period.
- R7: The prescale for tach division d (profile bits 2:1) is 4 << 2d cycles. If qualifying edges are D clock cycles apart, the posted count is floor((D-1)/prescale).
- R8: The window is the unit field (profile bits 31:16) times 2^WIN_SHIFT prescaled ticks, counted from the trigger. If it expires before a period completes, the result is done with a count of 0. Edge mode 11 never qualifies an edge.
- R9: The count saturates at 2^CNT_W-1 instead of wrapping.
- R10: Result bit 31 is done and bits 19:0 hold the count. All other bits read 0. The word holds steady until the next accepted trigger.
- R11: Map register (address 3) bit c selects profile 1 for channel c. When the bit is 0 the channel uses profile 0.
- R12: If the trigger word has several bits set, the lowest set bit selects the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 control, 1/2 profiles, 3 map, 4 trigger) |
| wr_data_i | input | 32 | Register write data |
| tach_i | input | NUM_CH | Asynchronous fan tach inputs |
| result_o | output | 32 | Done flag in bit 31, count in bits 19:0 |

## Verification
The hardest state to reach from the ports is a period long enough to saturate the counter without the window expiring first. The 20-bit default would need millions of cycles. The bench therefore builds the unit with a 10-bit count and a wide window, and holds one fan edge pair 5000 cycles apart. Timeout is reached in two ways: with a one-unit window and a silent input, and with the reserved edge mode while the input toggles. The remaining cases come from seeded random channel, mode, division and period choices, plus directed triggers aimed at the ignore paths.

// File: rtl/fan_tach_pkg.sv
`timescale 1ns/1ps
package fan_tach_pkg;
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_PROF0 = 3'd1;
  localparam logic [2:0] REG_PROF1 = 3'd2;
  localparam logic [2:0] REG_MAP   = 3'd3;
  localparam logic [2:0] REG_TRIG  = 3'd4;
  localparam int NUM_PROF = 2;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_COUNT} meas_st_e;

  typedef struct packed {
    logic [15:0] unit;
    edge_mode_e  mode;
    logic [1:0]  div;
    logic        en;
  } prof_t;

  function automatic prof_t word_to_prof(input logic [31:0] w);
    prof_t p;
    p.unit = w[31:16];
    p.mode = edge_mode_e'(w[5:4]);
    p.div  = w[2:1];
    p.en   = w[0];
    return p;
  endfunction

  // last prescaler count: (4 << 2*div) - 1
  function automatic logic [7:0] ps_last(input logic [1:0] div);
    logic [9:0] full;
    full = 10'd4 << {div, 1'b0};
    return 8'(full - 10'd1);
  endfunction
endpackage

// File: rtl/fan_tach_edges.sv
`timescale 1ns/1ps
module fan_tach_edges #(
  parameter int NUM_CH      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tach_i,
  output logic [NUM_CH-1:0] rise_o,
  output logic [NUM_CH-1:0] fall_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        last_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], tach_i[c]};
        last_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign rise_o[c] = sync_q[SYNC_STAGES-1] & ~last_q;
    assign fall_o[c] = ~sync_q[SYNC_STAGES-1] & last_q;
  end
endmodule

// File: rtl/fan_tach_regs.sv
`timescale 1ns/1ps
module fan_tach_regs import fan_tach_pkg::*; #(
  parameter  int NUM_CH = 16,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  output logic             start_o,
  output logic [CH_W-1:0]  start_ch_o,
  output edge_mode_e       start_mode_o,
  output logic [1:0]       start_div_o,
  output logic [15:0]      start_unit_o
);
  logic [NUM_CH-1:0] en_q, map_q, trig_q;
  prof_t             prof_q [NUM_PROF];
  logic              trig_wr;
  logic [NUM_CH-1:0] trig_new;
  logic [CH_W-1:0]   low_idx;
  prof_t             sel_prof;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      map_q  <= '0;
      trig_q <= '0;
      for (int p = 0; p < NUM_PROF; p++) prof_q[p] <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_CTRL:  en_q      <= wr_data_i[16 +: NUM_CH];
        REG_PROF0: prof_q[0] <= word_to_prof(wr_data_i);
        REG_PROF1: prof_q[1] <= word_to_prof(wr_data_i);
        REG_MAP:   map_q     <= wr_data_i[NUM_CH-1:0];
        REG_TRIG:  trig_q    <= wr_data_i[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  assign trig_wr  = wr_en_i && (wr_addr_i == REG_TRIG);
  assign trig_new = wr_data_i[NUM_CH-1:0];

  // lowest set bit wins
  always_comb begin
    low_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (trig_new[i]) low_idx = CH_W'(i);
    end
  end

  assign sel_prof     = prof_q[map_q[low_idx]];
  assign start_o      = trig_wr && (trig_q == '0) && (|trig_new) &&
                        en_q[low_idx] && sel_prof.en;
  assign start_ch_o   = low_idx;
  assign start_mode_o = sel_prof.mode;
  assign start_div_o  = sel_prof.div;
  assign start_unit_o = sel_prof.unit;

  // an accepted trigger leaves the register non-zero, so no back-to-back start
  p_single_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/fan_tach_meas.sv
`timescale 1ns/1ps
module fan_tach_meas import fan_tach_pkg::*; #(
  parameter  int NUM_CH    = 16,
  parameter  int CNT_W     = 20,
  parameter  int WIN_SHIFT = 6,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int WIN_W     = 16 + WIN_SHIFT,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   start_ch_i,
  input  edge_mode_e        start_mode_i,
  input  logic [1:0]        start_div_i,
  input  logic [15:0]       start_unit_i,
  input  logic [NUM_CH-1:0] rise_i,
  input  logic [NUM_CH-1:0] fall_i,
  output logic [31:0]       result_o
);
  meas_st_e         st_q;
  logic [CH_W-1:0]  ch_q;
  edge_mode_e       mode_q;
  logic [7:0]       ps_last_q, pre_q;
  logic [WIN_W-1:0] limit_q, win_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      result_q;
  logic             busy, tick, hit, timeout, to_fire;
  logic [WIN_W:0]   win_nx;

  function automatic logic [31:0] pack_res(input logic [CNT_W-1:0] c);
    logic [31:0] r;
    r = '0;
    r[31] = 1'b1;
    r[CNT_W-1:0] = c;
    return r;
  endfunction

  always_comb begin
    case (mode_q)
      EDGE_FALL: hit = fall_i[ch_q];
      EDGE_RISE: hit = rise_i[ch_q];
      EDGE_BOTH: hit = fall_i[ch_q] | rise_i[ch_q];
      default:   hit = 1'b0;
    endcase
  end

  assign busy    = (st_q != ST_IDLE);
  assign tick    = (pre_q == ps_last_q);
  assign win_nx  = {1'b0, win_q} + 1'b1;
  assign timeout = tick && (win_nx >= {1'b0, limit_q});
  assign to_fire = busy && !hit && timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ch_q      <= '0;
      mode_q    <= EDGE_FALL;
      ps_last_q <= '0;
      limit_q   <= '0;
      pre_q     <= '0;
      win_q     <= '0;
      cnt_q     <= '0;
      result_q  <= '0;
    end else if (start_i) begin
      st_q      <= ST_ARM;
      ch_q      <= start_ch_i;
      mode_q    <= start_mode_i;
      ps_last_q <= ps_last(start_div_i);
      limit_q   <= WIN_W'(start_unit_i) << WIN_SHIFT;
      pre_q     <= '0;
      win_q     <= '0;
      cnt_q     <= '0;
      result_q  <= '0;
    end else if (busy) begin
      pre_q <= tick ? 8'd0 : pre_q + 8'd1;
      if (tick) win_q <= win_q + 1'b1;
      if (hit) begin
        if (st_q == ST_ARM) begin
          // period starts: realign the prescaler to the edge
          st_q  <= ST_COUNT;
          pre_q <= '0;
          cnt_q <= '0;
        end else begin
          st_q     <= ST_IDLE;
          result_q <= pack_res(cnt_q);
        end
      end else if (timeout) begin
        st_q     <= ST_IDLE;
        result_q <= pack_res('0);
      end else if (tick && st_q == ST_COUNT && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign result_o = result_q;

  p_done_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !result_o[31]);

  p_timeout_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_fire && !start_i) |=> (result_o == 32'h8000_0000));

  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COUNT && cnt_q == CNT_MAX && !start_i) |=> (cnt_q == CNT_MAX));

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[31] && !start_i) |=> $stable(result_o));
endmodule

// File: rtl/fan_tach_unit.sv
`timescale 1ns/1ps
module fan_tach_unit import fan_tach_pkg::*; #(
  parameter  int NUM_CH      = 16,
  parameter  int CNT_W       = 20,
  parameter  int WIN_SHIFT   = 6,
  parameter  int SYNC_STAGES = 2,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [NUM_CH-1:0] tach_i,
  output logic [31:0]       result_o
);
  logic              start;
  logic [CH_W-1:0]   start_ch;
  edge_mode_e        start_mode;
  logic [1:0]        start_div;
  logic [15:0]       start_unit;
  logic [NUM_CH-1:0] rise, fall;

  fan_tach_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .start_o      (start),
    .start_ch_o   (start_ch),
    .start_mode_o (start_mode),
    .start_div_o  (start_div),
    .start_unit_o (start_unit)
  );

  fan_tach_edges #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tach_i (tach_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  fan_tach_meas #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .WIN_SHIFT(WIN_SHIFT)) u_meas (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_ch_i   (start_ch),
    .start_mode_i (start_mode),
    .start_div_i  (start_div),
    .start_unit_i (start_unit),
    .rise_i       (rise),
    .fall_i       (fall),
    .result_o     (result_o)
  );
endmodule

// File: tb/fan_tach_unit_tb.sv
`timescale 1ns/1ps
module fan_tach_unit_tb;
  localparam int CW = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_P0 = 3'd1, A_P1 = 3'd2, A_MAP = 3'd3, A_TRIG = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] tach = '0;
  logic [31:0] result;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fan_tach_unit #(.NUM_CH(16), .CNT_W(CW), .WIN_SHIFT(6), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tach_i(tach), .result_o(result)
  );

  function automatic logic [31:0] prof_word(input int unit, input int mode, input int div, input bit en);
    return {unit[15:0], 10'b0, mode[1:0], 1'b0, div[1:0], en};
  endfunction

  function automatic logic [31:0] exp_res(input int d, input int div);
    int ps, c;
    ps = 4 << (2 * div);
    c = (d - 1) / ps;
    if (c > (1 << CW) - 1) c = (1 << CW) - 1;
    return 32'h8000_0000 | 32'(c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(input int max_cyc);
    for (int i = 0; i < max_cyc; i++) begin
      if (result[31]) break;
      @(negedge clk);
    end
  endtask

  // one measurement: edges D cycles apart on channel ch
  task automatic run_meas(input int ch, input logic [15:0] trig, input int pidx,
                          input int mode, input int div, input int d, input int unit,
                          input logic [31:0] exp, input string req);
    logic lvl0;
    lvl0 = (mode == 0);
    tach[ch] = lvl0;
    repeat (6) @(negedge clk);
    wr(pidx != 0 ? A_P1 : A_P0, prof_word(unit, mode, div, 1'b1));
    wr(A_MAP, pidx != 0 ? (32'd1 << ch) : 32'd0);
    wr(A_TRIG, 32'd0);
    wr(A_TRIG, {16'd0, trig});
    check("R2 done cleared after trigger", {31'd0, result[31]}, 32'd0);
    repeat (5) @(negedge clk);
    if (mode == 2) begin
      tach[ch] = ~tach[ch];
      repeat (d) @(negedge clk);
      tach[ch] = ~tach[ch];
    end else begin
      tach[ch] = ~lvl0;
      repeat (d / 2) @(negedge clk);
      tach[ch] = lvl0;
      repeat (d - d / 2) @(negedge clk);
      tach[ch] = ~lvl0;
    end
    wait_done(d + 3000);
    check(req, result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after reset release", result, 32'd0);
    wr(A_CTRL, 32'hFFFF_0000);

    // directed patterns
    run_meas(2, 16'h0004, 0, 1, 0, 40, 200, exp_res(40, 0), "R5 R7 rising div0");
    run_meas(9, 16'h0200, 0, 0, 1, 100, 200, exp_res(100, 1), "R5 R7 falling div1");
    run_meas(4, 16'h0010, 0, 2, 0, 30, 200, exp_res(30, 0), "R6 both edges half period");

    // R10 hold while input keeps toggling
    prev = result;
    for (int k = 0; k < 6; k++) begin
      tach[4] = ~tach[4];
      repeat (9) @(negedge clk);
    end
    check("R10 result held after done", result, prev);
    check("R10 unused bits zero", result & 32'h7FF0_0000, 32'd0);

    // R4 re-trigger without writing zero
    wr(A_TRIG, 32'h0000_0010);
    repeat (3) @(negedge clk);
    check("R4 retrigger without zero ignored", result, prev);

    // R3 disabled channel
    wr(A_CTRL, 32'hFF7F_0000);
    wr(A_TRIG, 32'd0);
    wr(A_TRIG, 32'h0000_0080);
    repeat (3) @(negedge clk);
    check("R3 disabled channel ignored", result, prev);
    wr(A_CTRL, 32'hFFFF_0000);
    // R3 disabled profile
    wr(A_P0, prof_word(200, 1, 0, 1'b0));
    wr(A_MAP, 32'd0);
    wr(A_TRIG, 32'd0);
    wr(A_TRIG, 32'h0000_0080);
    repeat (3) @(negedge clk);
    check("R3 disabled profile ignored", result, prev);

    // R8 timeout on silent input
    wr(A_P0, prof_word(1, 1, 0, 1'b1));
    wr(A_TRIG, 32'd0);
    wr(A_TRIG, 32'h0000_0800);
    wait_done(3000);
    check("R8 window timeout zero count", result, 32'h8000_0000);

    // R8 reserved edge mode never qualifies
    wr(A_P0, prof_word(2, 3, 0, 1'b1));
    wr(A_TRIG, 32'd0);
    wr(A_TRIG, 32'h0000_0020);
    for (int k = 0; k < 10; k++) begin
      tach[5] = ~tach[5];
      repeat (20) @(negedge clk);
    end
    wait_done(3000);
    check("R8 reserved mode times out", result, 32'h8000_0000);

    // R11 profile map: profile 0 fast, channel mapped to profile 1 slow
    wr(A_P0, prof_word(200, 1, 0, 1'b1));
    run_meas(6, 16'h0040, 1, 1, 2, 300, 200, exp_res(300, 2), "R11 map selects profile 1");

    // R12 lowest set bit wins (ch5 silent would time out)
    run_meas(3, 16'h0028, 0, 1, 0, 40, 4, exp_res(40, 0), "R12 lowest trigger bit chosen");

    // R9 saturation
    run_meas(1, 16'h0002, 0, 1, 0, 5000, 40, 32'h8000_0000 | 32'((1 << CW) - 1), "R9 count saturates");

    // seeded random trials
    for (int t = 0; t < 8; t++) begin
      int ch, mode, div, d, pidx;
      ch   = int'($urandom % 16);
      mode = int'($urandom % 3);
      div  = int'($urandom % 3);
      d    = 20 + int'($urandom % 300);
      pidx = int'($urandom % 2);
      run_meas(ch, 16'(1 << ch), pidx, mode, div, d, 200, exp_res(d, div), "R7 random period");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule